// File: doc/BRIEF.md
# Power-Fail Protected Byte Memory

This block is a 2048-by-8 storage array behind a supply supervisor. Three digital comparator flags report the supply level: above the full-function level, above the write-protect level, and above the level where storage switches to the backup source. From these flags a state machine tracks whether the backup source is still under its factory seal. It also tracks whether the array is accessible, write-protected, held on battery, or locked out while power settles after it returns.

Accesses come in on a chip-select, write-strobe and output-enable interface, all active low, sampled on the clock. Reads and writes take effect only in the accessible state. In every other state the control lines are ignored and the data output enable stays low. Any chip-select pulse during the post-power-up lockout restarts the lockout and is counted. A supply collapse while the seal is still intact marks the contents as untrustworthy.

Top module: `nvram_guard`

## Requirements
- R1: While `rst` is high, the next clock edge puts `state_o` at 0 (sealed), `dout_oe` at 0, `data_valid` at 1 and `blocked_cnt` at 0.
- R2: In the sealed state, a cycle with `sup_sw` low clears `data_valid`. The flag never returns to 1 until reset, and it stays 1 while `sup_sw` is high.
- R3: In the sealed state, `sup_wp` high moves `state_o` to 4 (lockout) at the next edge. The sealed state is never entered again except by reset.
- R4: In lockout, `state_o` becomes 1 (accessible) after RECOVER_CYC consecutive edges with `sup_full` high and `ce_n` high. An edge with `ce_n` low restarts that count, performs no access, and increments `blocked_cnt`, which saturates at its maximum.
- R5: In the accessible state, an edge with `ce_n`=0 and `we_n`=0 stores `din` at `addr`.
- R6: In the accessible state, an edge with `ce_n`=0, `oe_n`=0 and `we_n`=1 drives the stored byte on `dout` with `dout_oe`=1 after that edge. If `we_n` is low, or the read condition is absent, `dout_oe` is 0.
- R7: The accessible state moves to 2 (protected) at the edge where `sup_wp` is low. It stays accessible while `sup_wp` is high, even if `sup_full` is low.
- R8: In states 0, 2, 3 and 4, writes leave the array unchanged and `dout_oe` stays 0, whatever the control inputs do.
- R9: Protected moves to 3 (battery) when `sup_sw` is low. Battery returns to protected when `sup_sw` is high.
- R10: Protected moves to lockout when `sup_full` is high. Bytes written before a power-down read back unchanged once the block is accessible again.
- R11: In lockout, `sup_wp` low moves to protected. `sup_full` low with `sup_wp` high keeps the block in lockout and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_full | input | 1 | Supply above full-function level |
| sup_wp | input | 1 | Supply above write-protect level |
| sup_sw | input | 1 | Supply above backup switchover level |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Drive enable for the data bus |
| state_o | output | 3 | Supervisor state code |
| data_valid | output | 1 | Contents trusted |
| blocked_cnt | output | CNT_W | Access attempts refused during lockout |

## Verification
The assertions assume the comparator flags are monotonic in the supply level: `sup_full` implies `sup_wp`, and `sup_wp` implies `sup_sw`. A legal flag set therefore maps to one of four levels. The stimulus sets the supply as a level from 0 to 3 and derives all three flags from it, so an inconsistent combination never reaches the block. Random data and addresses come from a fixed-seed generator. The power sequences are directed, and random plunge depths are mixed in.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  typedef enum logic [2:0] {
    ST_SEALED = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } nvg_state_e;
endpackage

// File: rtl/nvg_supervisor.sv
module nvg_supervisor
  import nvg_pkg::*;
#(
  parameter int RECOVER_CYC = 1000,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sup_full,
  input  logic             sup_wp,
  input  logic             sup_sw,
  input  logic             ce_n,
  output nvg_state_e       state,
  output logic             data_valid,
  output logic [CNT_W-1:0] blocked_cnt
);
  localparam int TMR_W = $clog2(RECOVER_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(RECOVER_CYC - 1);

  nvg_state_e       nxt;
  logic [TMR_W-1:0] timer;
  logic             settle_ok;

  assign settle_ok = sup_full && ce_n;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SEALED: if (sup_wp) nxt = ST_RECOV;
      ST_RECOV: begin
        if (!sup_wp) nxt = ST_PROT;
        else if (settle_ok && timer == TMR_LAST) nxt = ST_ACTIVE;
      end
      ST_ACTIVE: if (!sup_wp) nxt = ST_PROT;
      ST_PROT: begin
        if (!sup_sw) nxt = ST_BATT;
        else if (sup_full) nxt = ST_RECOV;
      end
      ST_BATT: if (sup_sw) nxt = ST_PROT;
      default: nxt = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SEALED;
      timer       <= '0;
      data_valid  <= 1'b1;
      blocked_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_RECOV && nxt == ST_RECOV && settle_ok) timer <= timer + 1'b1;
      else timer <= '0;
      if (state == ST_SEALED && !sup_sw) data_valid <= 1'b0;
      if (state == ST_RECOV && !ce_n && blocked_cnt != {CNT_W{1'b1}})
        blocked_cnt <= blocked_cnt + 1'b1;
    end
  end

  // R3
  seal_once_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SEALED) |=> (state != ST_SEALED));
  // R9
  batt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_PROT && state != ST_BATT) |=> (state != ST_BATT));
  // R4
  active_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RECOV && state != ST_ACTIVE) |=> (state != ST_ACTIVE));
  // R2
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> !data_valid);
  // R4
  blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RECOV) |=> $stable(blocked_cnt));
endmodule

// File: rtl/nvg_store.sv
module nvg_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvram_guard.sv
module nvram_guard
  import nvg_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int RECOVER_CYC = 1000,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sup_full,
  input  logic              sup_wp,
  input  logic              sup_sw,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [2:0]        state_o,
  output logic              data_valid,
  output logic [CNT_W-1:0]  blocked_cnt
);
  nvg_state_e st;
  logic       open_bus;
  logic       mem_we;
  logic       rd_req;

  nvg_supervisor #(.RECOVER_CYC(RECOVER_CYC), .CNT_W(CNT_W)) u_sup (
    .clk(clk), .rst(rst), .sup_full(sup_full), .sup_wp(sup_wp),
    .sup_sw(sup_sw), .ce_n(ce_n), .state(st),
    .data_valid(data_valid), .blocked_cnt(blocked_cnt)
  );

  assign open_bus = (st == ST_ACTIVE);
  assign mem_we   = open_bus && !ce_n && !we_n;
  assign rd_req   = open_bus && !ce_n && !oe_n && we_n;

  nvg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(din), .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_oe <= 1'b0;
    else     dout_oe <= rd_req;
  end

  assign state_o = st;

  // R8
  no_drive_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_ACTIVE) |=> !dout_oe);
  // R6
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n) |=> !dout_oe);
endmodule

// File: tb/nvram_guard_tb.sv
module nvram_guard_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int RC = 12;
  localparam int NW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_full = 1'b0, sup_wp = 1'b0, sup_sw = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;
  logic [2:0] state_o;
  logic data_valid;
  logic [7:0] blocked_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [AW-1:0] alist [NW];
  logic [DW-1:0] shadow [NW];

  always #4 clk = ~clk;

  nvram_guard #(.ADDR_W(AW), .DATA_W(DW), .RECOVER_CYC(RC), .CNT_W(8)) u_dut (
    .clk(clk), .rst(rst), .sup_full(sup_full), .sup_wp(sup_wp), .sup_sw(sup_sw),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .state_o(state_o),
    .data_valid(data_valid), .blocked_cnt(blocked_cnt)
  );

  function automatic logic [AW-1:0] slot_addr(int i, int r);
    return AW'(i * 64 + (r % 64));
  endfunction

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_lvl(int l);
    sup_sw = (l >= 1);
    sup_wp = (l >= 2);
    sup_full = (l >= 3);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    tick();
    idle();
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] e);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    tick();
    chk(req, dout, e);
    chk(req, dout_oe, 1);
    idle();
  endtask

  task automatic verify_all(string req);
    for (int i = 0; i < NW; i++) rd_chk(req, alist[i], shadow[i]);
    tick();
    chk(req, dout_oe, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    set_lvl(0);
    tick(2);
    chk("R1 state", state_o, 0);
    chk("R1 oe", dout_oe, 0);
    chk("R1 valid", data_valid, 1);
    chk("R1 blocked", blocked_cnt, 0);
    // R2: switchover flag high keeps contents trusted in seal
    set_lvl(1);
    rst = 1'b0;
    tick(3);
    chk("R2 state sealed", state_o, 0);
    chk("R2 valid kept", data_valid, 1);
    // R3 seal break
    set_lvl(2);
    tick();
    chk("R3 to lockout", state_o, 4);
    // R11 lockout holds with only wp flag
    tick(RC + 2);
    chk("R11 hold no full", state_o, 4);
    // R4 lockout with a refused access
    set_lvl(3);
    tick(5);
    ce_n = 1'b0; we_n = 1'b0; addr = 5; din = 8'hAA;
    tick();
    idle();
    chk("R4 blocked count", blocked_cnt, 1);
    chk("R4 still lockout", state_o, 4);
    tick(RC - 1);
    chk("R4 before expiry", state_o, 4);
    tick();
    chk("R4 active", state_o, 1);
    // R5 R6 random writes and reads
    for (int i = 0; i < NW; i++) begin
      alist[i] = slot_addr(i, int'($urandom));
      shadow[i] = DW'($urandom);
      wr(alist[i], shadow[i]);
    end
    tick();
    chk("R6 idle oe", dout_oe, 0);
    verify_all("R5");
    // R6 write with output enable low: no drive
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = alist[0]; din = 8'h3C;
    shadow[0] = 8'h3C;
    tick();
    chk("R6 we blocks drive", dout_oe, 0);
    idle();
    rd_chk("R5 overwrite", alist[0], 8'h3C);
    // R7 power-down
    set_lvl(2);
    tick();
    chk("R7 stays active", state_o, 1);
    set_lvl(1);
    tick();
    chk("R7 protected", state_o, 2);
    // R8 blocked in protected
    wr(alist[1], ~shadow[1]);
    chk("R8 no drive prot w", dout_oe, 0);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = alist[1];
    tick();
    chk("R8 no drive prot r", dout_oe, 0);
    idle();
    // R9 battery
    set_lvl(0);
    tick();
    chk("R9 battery", state_o, 3);
    wr(alist[2], ~shadow[2]);
    chk("R8 no drive batt", dout_oe, 0);
    set_lvl(1);
    tick();
    chk("R9 back to prot", state_o, 2);
    set_lvl(0);
    tick();
    chk("R9 battery again", state_o, 3);
    set_lvl(2);
    tick();
    chk("R10 prot without full", state_o, 2);
    set_lvl(3);
    tick();
    chk("R10 lockout", state_o, 4);
    // R8 refused write in lockout
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = alist[3]; din = ~shadow[3];
    tick();
    idle();
    chk("R4 blocked count 2", blocked_cnt, 2);
    chk("R8 no drive lockout", dout_oe, 0);
    tick(3);
    set_lvl(2);
    tick();
    chk("R11 restart", state_o, 4);
    set_lvl(3);
    tick(RC - 1);
    chk("R11 count restarted", state_o, 4);
    tick();
    chk("R10 active again", state_o, 1);
    verify_all("R10");
    // random plunges
    for (int it = 0; it < 3; it++) begin
      int depth;
      depth = int'($urandom % 2);
      set_lvl(1);
      tick();
      chk("R7 prot", state_o, 2);
      set_lvl(depth);
      tick();
      chk("R9 depth", state_o, (depth == 0) ? 3 : 2);
      wr(alist[int'($urandom % NW)], DW'($urandom));
      chk("R8 random", dout_oe, 0);
      set_lvl(3);
      tick((depth == 0) ? 2 : 1);
      chk("R10 lockout", state_o, 4);
      tick(3);
      set_lvl(1);
      tick();
      chk("R11 drop", state_o, 2);
      set_lvl(3);
      tick();
      chk("R10 relock", state_o, 4);
      tick(RC);
      chk("R4 active", state_o, 1);
      verify_all("R10");
    end
    // R2 second session: seal with supply collapse
    rst = 1'b1;
    set_lvl(0);
    tick(2);
    chk("R1 blocked", blocked_cnt, 0);
    rst = 1'b0;
    tick();
    chk("R2 invalid", data_valid, 0);
    set_lvl(2);
    tick();
    chk("R3 lockout", state_o, 4);
    chk("R2 sticky", data_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule